// File: doc/BRIEF.md
# Double-Banked Colour Palette

This block converts 8-bit pixel indices into 24-bit RGB colours through a 256-entry palette held twice. One copy, the live bank, feeds the display path. The other, the shadow bank, is what software sees through the register port. Software fills the shadow bank at its own pace while the display keeps reading a complete, unchanging palette.

To publish a new palette, software flips a swap-request bit in the control word. At the next frame-start pulse the banks trade roles and a status bit is set equal to the request bit. The status bit also names the live bank. When request and status match, no swap is pending and the shadow bank may be rewritten. A mismatch means a swap is still waiting for the frame boundary, and software should not touch the shadow bank until it completes.

The register port uses byte addresses. The control word sits at offset 0x000. Palette entry n sits at offset 0x400 + 4·n. Reads return data one cycle after the read strobe. Pixel lookups are pipelined, one result per cycle.

Top module: `palette_dbank`

## Requirements
- R1: After reset, bank 0 is live, the request and status bits are both 0, a read of the control word returns 0, and `rgb_valid` and `rgb` are 0.
- R2: Writing the control word (offset 0x000) loads bit 0 into the swap-request bit. Bit 1 is read-only status, and writes to it and to all higher bits have no effect. A control read returns the request in bit 0, the status in bit 1, and zeros elsewhere.
- R3: The status bit changes only on a cycle with `frame_start` high. On that cycle it takes the request value held before the edge, and the live bank then equals the status bit.
- R4: A palette write at offset 0x400 + 4·n (address bits [1:0] ignored) updates entry n of the shadow bank, which is the bank not equal to the status bit. Pixel lookups do not see the write until a later swap.
- R5: An entry holds red in bits [23:16], green in [15:8] and blue in [7:0]. Write bits [31:24] are discarded, and a palette read returns 0 in bits [31:24].
- R6: A pixel index presented with `pix_valid` high yields its live-bank colour on `rgb`, with `rgb_valid` high, exactly one cycle later. Back-to-back indices stream at one per cycle. A cycle without `pix_valid` yields `rgb_valid` = 0 and `rgb` = 0 one cycle later.
- R7: A read strobe loads `reg_rdata` one cycle later, and the value holds until the next read. A palette read returns the shadow-bank entry.
- R8: A pixel sampled on the same cycle as `frame_start` uses the bank that was live before the swap. The pixel on the following cycle uses the new bank.
- R9: If the request bit is flipped and then flipped back before a frame start, the next frame start causes no swap, and the live bank and the status bit are unchanged.
- R10: Offsets that are neither the control word nor inside the palette window are unmapped. Writes there change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 11 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, loaded one cycle after `reg_re` |
| frame_start | input | 1 | One-cycle pulse at the frame boundary |
| pix_valid | input | 1 | Pixel index strobe |
| pix_idx | input | 8 | Pixel palette index |
| rgb_valid | output | 1 | Colour output valid |
| rgb | output | 24 | Colour output, R[23:16] G[15:8] B[7:0] |

## Verification
Every result of this block lands one register stage after its cause:
- the pixel colour and its valid flag follow the index by one cycle;
- read data follows the read strobe by one cycle;
- the status bit and the bank roles change at the edge that samples `frame_start`.

The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so each check sees exactly the one cycle it targets. During a swap, the pixel sampled on the frame-start edge and the pixel on the next cycle are checked separately, pinning the old-bank and new-bank cycles.

// File: rtl/palette_dbank_pkg.sv
package palette_dbank_pkg;
  localparam int CH_W     = 8;
  localparam int RGB_W    = 3 * CH_W;
  localparam int WORD_W   = 32;
  localparam int REQ_BIT  = 0;
  localparam int STAT_BIT = 1;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
  } rgb_t;

  // Bus word to palette entry: bits above the colour field are dropped (R5).
  function automatic rgb_t word_to_rgb(input logic [WORD_W-1:0] w);
    return rgb_t'(w[RGB_W-1:0]);
  endfunction

  // Palette entry to bus word: upper bits read as zero (R5).
  function automatic logic [WORD_W-1:0] rgb_to_word(input rgb_t c);
    return {{(WORD_W-RGB_W){1'b0}}, c};
  endfunction

  // Control word: request in bit 0, status in bit 1, zeros elsewhere (R2).
  function automatic logic [WORD_W-1:0] ctrl_word(input logic req, input logic stat);
    logic [WORD_W-1:0] w;
    w = '0;
    w[REQ_BIT]  = req;
    w[STAT_BIT] = stat;
    return w;
  endfunction
endpackage

// File: rtl/palette_decode.sv
module palette_decode #(
  parameter int ADDR_W   = 11,
  parameter int IDX_W    = 8,
  parameter int CTRL_OFS = 'h000,
  parameter int PAL_OFS  = 'h400
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_sel,
  output logic              pal_sel,
  output logic [IDX_W-1:0]  pal_idx
);
  localparam int TAG_LSB = IDX_W + 2;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam logic [TAG_W-1:0]  PAL_TAG = TAG_W'(PAL_OFS >> TAG_LSB);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);

  // The palette window is aligned to its own size, so only the tag bits are compared.
  function automatic logic in_palette(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:TAG_LSB] == PAL_TAG;
  endfunction

  // Entry number of a word-aligned palette address; bits [1:0] are ignored (R4).
  function automatic logic [IDX_W-1:0] entry_of(input logic [ADDR_W-1:0] a);
    return a[TAG_LSB-1:2];
  endfunction

  always_comb begin
    ctrl_sel = (addr == CTRL_A);
    pal_sel  = in_palette(addr);
    pal_idx  = entry_of(addr);
  end
endmodule

// File: rtl/palette_bank_ctrl.sv
module palette_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic req_in,
  input  logic frame_start,
  output logic sw_req,
  output logic sw_stat,
  output logic swap_fire
);
  // Status copies the request only at a frame boundary (R3). A request that
  // was flipped and restored before the boundary then swaps nothing (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_req  <= 1'b0;
      sw_stat <= 1'b0;
    end else begin
      if (ctrl_we)     sw_req  <= req_in;
      if (frame_start) sw_stat <= sw_req;
    end
  end

  assign swap_fire = frame_start & (sw_req != sw_stat);
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_dbank_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int NBANK = 2
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [IDX_W-1:0] wr_idx,
  input  rgb_t             wr_data,
  input  logic             pix_bank,
  input  logic [IDX_W-1:0] pix_idx,
  output rgb_t             pix_data,
  input  logic             reg_bank,
  input  logic [IDX_W-1:0] reg_idx,
  output rgb_t             reg_data
);
  localparam int DEPTH = 1 << IDX_W;

  rgb_t bank_pix [NBANK];
  rgb_t bank_reg [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rgb_t mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_idx] <= wr_data;
    end
    assign bank_pix[b] = mem[pix_idx];
    assign bank_reg[b] = mem[reg_idx];
  end

  assign pix_data = bank_pix[pix_bank];
  assign reg_data = bank_reg[reg_bank];
endmodule

// File: rtl/palette_pixel_pipe.sv
module palette_pixel_pipe
  import palette_dbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  rgb_t             pix_entry,
  output logic             rgb_valid,
  output logic [RGB_W-1:0] rgb
);
  // One register stage; idle cycles drive zero colour (R6).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb       <= '0;
    end else begin
      rgb_valid <= pix_valid;
      rgb       <= pix_valid ? pix_entry : '0;
    end
  end
endmodule

// File: rtl/palette_dbank.sv
module palette_dbank
  import palette_dbank_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int IDX_W    = 8,
  parameter int CTRL_OFS = 'h000,
  parameter int PAL_OFS  = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic              rgb_valid,
  output logic [RGB_W-1:0]  rgb
);
  logic             ctrl_sel, pal_sel;
  logic [IDX_W-1:0] pal_idx;
  logic             sw_req, sw_stat, swap_fire;
  logic             ctrl_wr_fire, pal_wr_fire;
  logic             live_bank, shadow_bank;
  rgb_t             pix_entry, shadow_entry;
  logic [WORD_W-1:0] rd_next;

  palette_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CTRL_OFS(CTRL_OFS), .PAL_OFS(PAL_OFS)
  ) u_dec (
    .addr(reg_addr), .ctrl_sel(ctrl_sel), .pal_sel(pal_sel), .pal_idx(pal_idx)
  );

  assign ctrl_wr_fire = reg_we & ctrl_sel;
  assign pal_wr_fire  = reg_we & pal_sel;   // unmapped writes fire nothing (R10)

  palette_bank_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_wr_fire), .req_in(reg_wdata[REQ_BIT]),
    .frame_start(frame_start), .sw_req(sw_req), .sw_stat(sw_stat), .swap_fire(swap_fire)
  );

  // The status bit names the live bank; the register port owns the other (R4, R7).
  assign live_bank   = sw_stat;
  assign shadow_bank = ~sw_stat;

  palette_store #(.IDX_W(IDX_W), .NBANK(2)) u_store (
    .clk(clk), .wr_en(pal_wr_fire), .wr_bank(shadow_bank), .wr_idx(pal_idx),
    .wr_data(word_to_rgb(reg_wdata)),
    .pix_bank(live_bank), .pix_idx(pix_idx), .pix_data(pix_entry),
    .reg_bank(shadow_bank), .reg_idx(pal_idx), .reg_data(shadow_entry)
  );

  palette_pixel_pipe u_pix (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_entry(pix_entry),
    .rgb_valid(rgb_valid), .rgb(rgb)
  );

  always_comb begin
    if (ctrl_sel)     rd_next = ctrl_word(sw_req, sw_stat);
    else if (pal_sel) rd_next = rgb_to_word(shadow_entry);
    else              rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/palette_dbank_chk.sv
module palette_dbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic        ctrl_wr_fire,
  input logic        req_bit_in,
  input logic        pal_wr_fire,
  input logic        shadow_bank,
  input logic        sw_req,
  input logic        sw_stat,
  input logic        swap_fire,
  input logic        pix_valid,
  input logic        rgb_valid,
  input logic [23:0] rgb
);
  // R3
  stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> sw_stat == $past(sw_req));
  // R3
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(sw_stat));
  // R9
  no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !swap_fire) |=> $stable(sw_stat));
  // R2
  req_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_fire |=> sw_req == $past(req_bit_in));
  // R4
  shadow_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_wr_fire |-> shadow_bank != sw_stat);
  // R6
  pix_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> rgb_valid);
  // R6
  pix_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!rgb_valid && rgb == 24'h0));
endmodule

bind palette_dbank palette_dbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ctrl_wr_fire(ctrl_wr_fire),
  .req_bit_in(reg_wdata[0]), .pal_wr_fire(pal_wr_fire), .shadow_bank(shadow_bank),
  .sw_req(sw_req), .sw_stat(sw_stat), .swap_fire(swap_fire), .pix_valid(pix_valid),
  .rgb_valid(rgb_valid), .rgb(rgb)
);

// File: tb/sim_palette_dbank.sv
`timescale 1ns/1ps
module sim_palette_dbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [10:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        rgb_valid;
  logic [23:0] rgb;
  int checks = 0, errors = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  palette_dbank u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_idx(pix_idx), .rgb_valid(rgb_valid), .rgb(rgb)
  );

  function automatic logic [23:0] pat_a(input int i);
    return {8'(i), 8'(i * 7 + 3), 8'(255 - i)};
  endfunction
  function automatic logic [23:0] pat_b(input int i);
    return {8'(i * 13 + 1), 8'(i ^ 8'h5A), 8'(i * 3)};
  endfunction
  function automatic logic [10:0] ent(input int i);
    return 11'(16'h400 + i * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rdreg(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pix_one(input int i, input logic [23:0] exp, input string req);
    @(negedge clk); pix_valid = 1'b1; pix_idx = 8'(i);
    @(posedge clk); #1 chk(req, {7'h0, rgb_valid, rgb}, {8'h01, exp});
    @(negedge clk); pix_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(posedge clk); #1 chk("R1 rgb", {7'h0, rgb_valid, rgb}, 32'h0);
    rdreg(11'h000, rd); chk("R1 ctrl", rd, 32'h0);

    // R4 R5: fill shadow bank 1 with junk in the top byte
    for (int i = 0; i < 256; i++) wr(ent(i), {8'hC3, pat_a(i)});
    // R7 R5: read back the shadow bank
    for (int i = 0; i < 256; i++) begin
      rdreg(ent(i), rd); chk("R7 R5 readback A", rd, {8'h00, pat_a(i)});
    end
    // R2: request loaded, status unchanged before the frame
    wr(11'h000, 32'h1);
    rdreg(11'h000, rd); chk("R2 pending", rd, 32'h1);
    frame();
    rdreg(11'h000, rd); chk("R3 swapped", rd, 32'h3);

    // R6: streaming sweep of the live bank, one index per cycle
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); pix_valid = 1'b1; pix_idx = 8'(i);
      @(posedge clk); #1 chk("R6 stream A", {7'h0, rgb_valid, rgb}, {8'h01, pat_a(i)});
    end
    @(negedge clk); pix_valid = 1'b0;
    @(posedge clk); #1 chk("R6 idle", {7'h0, rgb_valid, rgb}, 32'h0);

    // R4: shadow is now bank 0; writes must not reach the display
    for (int i = 0; i < 256; i++) wr(ent(i) | 11'(i % 4), {8'hFF, pat_b(i)});
    pix_one(17, pat_a(17), "R4 live untouched");
    pix_one(200, pat_a(200), "R4 live untouched");
    rdreg(ent(17), rd);  chk("R7 shadow B", rd, {8'h00, pat_b(17)});
    rdreg(ent(255), rd); chk("R7 shadow B", rd, {8'h00, pat_b(255)});

    // R9: flip and restore the request, then frame: no swap
    wr(11'h000, 32'h0);
    wr(11'h000, 32'h1);
    frame();
    rdreg(11'h000, rd); chk("R9 ctrl", rd, 32'h3);
    pix_one(42, pat_a(42), "R9 live kept");
    // R3: frame without a request changes nothing
    frame();
    rdreg(11'h000, rd); chk("R3 stable", rd, 32'h3);

    // R8: swap back; the pixel on the frame edge uses the old bank
    wr(11'h000, 32'h0);
    @(negedge clk); frame_start = 1'b1; pix_valid = 1'b1; pix_idx = 8'd5;
    @(posedge clk); #1 chk("R8 old bank", {7'h0, rgb_valid, rgb}, {8'h01, pat_a(5)});
    @(negedge clk); frame_start = 1'b0; pix_idx = 8'd5;
    @(posedge clk); #1 chk("R8 new bank", {7'h0, rgb_valid, rgb}, {8'h01, pat_b(5)});
    @(negedge clk); pix_valid = 1'b0;
    rdreg(11'h000, rd); chk("R3 back", rd, 32'h0);
    for (int i = 0; i < 256; i += 51) pix_one(i, pat_b(i), "R6 live B");

    // R10: unmapped accesses
    wr(11'h200, 32'h00ABCDEF);
    rdreg(11'h200, rd); chk("R10 read", rd, 32'h0);
    rdreg(11'h004, rd); chk("R10 read", rd, 32'h0);
    rdreg(ent(128), rd); chk("R10 palette kept", rd, {8'h00, pat_a(128)});
    // R7: read data holds without a strobe
    repeat (3) @(posedge clk);
    #1 chk("R7 hold", reg_rdata, {8'h00, pat_a(128)});

    // R2: status bit and upper bits are not writable
    wr(11'h000, 32'hFFFF_FFFE);
    rdreg(11'h000, rd); chk("R2 read-only", rd, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule